// File: doc/BRIEF.md
# Shared Processor Miscellaneous Control Register

This block is one 64-bit control and status register that four processors share. It keeps a pending bit per processor for inter-processor interrupts and another for interval timer interrupts, and it tracks bus arbitration in two 4-bit fields. Each field has its own write rule. Some fields clear when a 1 is written to them. One field sets when a 1 is written to it. One field sets only while it holds all zeros. A single data bit clears both arbitration fields. A separate group of request bits sets the inter-processor pending bits and is never stored. A small user field is plain read/write.

Each processor's inter-processor interrupt output and timer interrupt output follow that processor's pending bit. The interval counter block raises a timer pending bit through a one-cycle pulse per processor. A write can clear a timer pending bit but cannot set it. A read returns the stored value with the requesting processor's 2-bit ID ORed into bits 1:0. The write port and the read port are plain control pins. A write takes effect on the clock edge where `csr_wr_en` is high. The read path is combinational and always valid, so the interface has no back-pressure.

Top module: `sysmisc_ctl`

## Requirements
- R1: After reset every stored bit is 0. `ipi_irq` and `tmr_irq` are 0, and a read returns only the requester ID.
- R2: Within a write, a 1 in data bits 4..11 or bit 28 clears that stored bit, and a 0 leaves it unchanged. Bit 28 is never set, so it always reads 0.
- R3: Stored bits 4..7 are the timer pending bits for processors 0..3. A write never sets them. A high `tmr_set_pulse[i]` sets bit 4+i, and this set wins over a clear of that bit in the same cycle.
- R4: A 1 in write data bits 12..15 sets stored bit 8..11 respectively, and this set is applied after the clears of R2 in the same write. Bits 12..15 always read 0.
- R5: When write data bit 20 is 1, stored bits 16..23 are cleared before any set in the same write is applied.
- R6: A 1 in write data bits 20..23 sets the matching stored bit (write-1-to-set).
- R7: Stored bits 16..19 take the write data bits 16..19 (ORed in) only if they are all 0 after the R5 clear. Otherwise the write leaves them unchanged.
- R8: Stored bits 40..43 load write data bits 40..43 on every write.
- R9: `rd_data` equals the stored value with `rd_cpu_id` placed in bits 1..0.
- R10: Every bit not named in R2..R8 reads 0 and ignores writes.
- R11: `ipi_irq[i]` equals stored bit 8+i and `tmr_irq[i]` equals stored bit 4+i. Both change on the clock edge that changes the stored bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr_en | input | 1 | Write strobe, one write per high cycle |
| csr_wr_data | input | 64 | Write data, decoded per field |
| rd_cpu_id | input | 2 | ID of the processor issuing the read |
| rd_data | output | 64 | Read data: stored value ORed with `rd_cpu_id` |
| tmr_set_pulse | input | 4 | Per-processor timer pending set pulse |
| ipi_irq | output | 4 | Per-processor inter-processor interrupt |
| tmr_irq | output | 4 | Per-processor interval timer interrupt |

## Verification
The register's whole state appears at `rd_data` in the same cycle, and the interrupt pins mirror the pending fields. A wrong update therefore shows up one clock after the write or pulse that caused it. An error in merge order shows only when one write carries both a clear and a set for the same field, such as a pending clear together with a request, or a bit-20 clear together with arbitration sets. A misplaced conditional set shows only while the arbitration field is already nonzero. The sweep below therefore reads the register back after every write and pulse, and it combines these bits freely so that both cases occur.

// File: rtl/sysmisc_pkg.sv
package sysmisc_pkg;
  localparam int REG_W    = 64;
  localparam int NCPU     = 4;
  localparam int ID_W     = $clog2(NCPU);
  localparam int TMR_LSB  = 4;
  localparam int IPI_LSB  = TMR_LSB + NCPU;
  localparam int REQ_LSB  = IPI_LSB + NCPU;
  localparam int ARBW_LSB = 16;
  localparam int ARBT_LSB = ARBW_LSB + NCPU;
  localparam int ARBCLR   = ARBT_LSB;
  localparam int ERR_BIT  = 28;
  localparam int USR_LSB  = 40;
  localparam int USR_W    = 4;

  function automatic logic [REG_W-1:0] field_mask(int lsb, int w);
    logic [REG_W-1:0] m;
    m = '0;
    for (int b = 0; b < w; b++) m[lsb+b] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] W1C_MASK =
    field_mask(TMR_LSB, NCPU) | field_mask(IPI_LSB, NCPU) | field_mask(ERR_BIT, 1);
  localparam logic [REG_W-1:0] KEEP_MASK =
    W1C_MASK | field_mask(ARBW_LSB, 2*NCPU) | field_mask(USR_LSB, USR_W);
endpackage

// File: rtl/sysmisc_next.sv
module sysmisc_next
  import sysmisc_pkg::*;
(
  input  logic [REG_W-1:0] cur,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic [NCPU-1:0]  tmr_set,
  output logic [REG_W-1:0] nxt
);
  logic [REG_W-1:0] v;

  always_comb begin
    v = cur;
    if (wr_en) begin
      // clears first
      v = v & ~(wdata & W1C_MASK);
      if (wdata[ARBCLR]) v[ARBW_LSB +: 2*NCPU] = '0;
      // then sets
      v[ARBT_LSB +: NCPU] = v[ARBT_LSB +: NCPU] | wdata[ARBT_LSB +: NCPU];
      if (v[ARBW_LSB +: NCPU] == '0)
        v[ARBW_LSB +: NCPU] = wdata[ARBW_LSB +: NCPU];
      v[IPI_LSB +: NCPU] = v[IPI_LSB +: NCPU] | wdata[REQ_LSB +: NCPU];
      v[USR_LSB +: USR_W] = wdata[USR_LSB +: USR_W];
    end
    v[TMR_LSB +: NCPU] = v[TMR_LSB +: NCPU] | tmr_set;
    nxt = v & KEEP_MASK;
  end
endmodule

// File: rtl/sysmisc_rdmux.sv
module sysmisc_rdmux
  import sysmisc_pkg::*;
(
  input  logic [REG_W-1:0] stored,
  input  logic [ID_W-1:0]  cpu_id,
  output logic [REG_W-1:0] rd_data
);
  always_comb begin
    rd_data = stored;
    rd_data[ID_W-1:0] = stored[ID_W-1:0] | cpu_id;
  end
endmodule

// File: rtl/sysmisc_ctl.sv
module sysmisc_ctl
  import sysmisc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr_en,
  input  logic [REG_W-1:0] csr_wr_data,
  input  logic [ID_W-1:0]  rd_cpu_id,
  output logic [REG_W-1:0] rd_data,
  input  logic [NCPU-1:0]  tmr_set_pulse,
  output logic [NCPU-1:0]  ipi_irq,
  output logic [NCPU-1:0]  tmr_irq
);
  logic [REG_W-1:0] q;
  logic [REG_W-1:0] q_nxt;

  sysmisc_next u_next (
    .cur     (q),
    .wr_en   (csr_wr_en),
    .wdata   (csr_wr_data),
    .tmr_set (tmr_set_pulse),
    .nxt     (q_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  sysmisc_rdmux u_rd (
    .stored  (q),
    .cpu_id  (rd_cpu_id),
    .rd_data (rd_data)
  );

  for (genvar i = 0; i < NCPU; i++) begin : g_irq
    assign ipi_irq[i] = q[IPI_LSB+i];
    assign tmr_irq[i] = q[TMR_LSB+i];
  end

  assert_tmr_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((q[TMR_LSB +: NCPU] & ~$past(q[TMR_LSB +: NCPU]) & ~$past(tmr_set_pulse)) == '0));

  assert_ipi_only_by_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((q[IPI_LSB +: NCPU] & ~$past(q[IPI_LSB +: NCPU]) &
      ~($past(csr_wr_en) ? $past(csr_wr_data[REQ_LSB +: NCPU]) : '0)) == '0));

  assert_arbt_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr_en |=> ((q[ARBT_LSB +: NCPU] & $past(csr_wr_data[ARBT_LSB +: NCPU]))
                    == $past(csr_wr_data[ARBT_LSB +: NCPU])));

  assert_arbw_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(q[ARBW_LSB +: NCPU]) != '0) &&
     !($past(csr_wr_en) && $past(csr_wr_data[ARBCLR])))
    |-> (q[ARBW_LSB +: NCPU] == $past(q[ARBW_LSB +: NCPU])));

  assert_usr_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr_en |=> (q[USR_LSB +: USR_W] == $past(csr_wr_data[USR_LSB +: USR_W])));

  assert_undef_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data & ~(KEEP_MASK | REG_W'((1 << ID_W) - 1))) == '0));
endmodule

// File: tb/sysmisc_ctl_bench.sv
module sysmisc_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wdata = '0;
  logic [1:0]  rid = '0;
  logic [63:0] rdata;
  logic [3:0]  tset = '0;
  logic [3:0]  ipi, tmr;

  int checks = 0;
  int fails  = 0;
  logic [63:0] model = '0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #10 clk = ~clk;

  sysmisc_ctl u_sysmisc_ctl (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(wr_en), .csr_wr_data(wdata),
    .rd_cpu_id(rid), .rd_data(rdata), .tmr_set_pulse(tset),
    .ipi_irq(ipi), .tmr_irq(tmr)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected next value, written bit by bit from the requirements
  function automatic logic [63:0] ref_next(logic [63:0] o, logic we, logic [63:0] d, logic [3:0] ts);
    logic [63:0] n;
    logic anyw;
    n = o;
    if (we) begin
      for (int b = 4; b <= 11; b++) if (d[b]) n[b] = 1'b0;   // R2
      if (d[28]) n[28] = 1'b0;
      if (d[20]) for (int b = 16; b <= 23; b++) n[b] = 1'b0; // R5
      for (int b = 20; b <= 23; b++) if (d[b]) n[b] = 1'b1;  // R6
      anyw = 1'b0;
      for (int b = 16; b <= 19; b++) anyw = anyw | n[b];
      if (!anyw) for (int b = 16; b <= 19; b++) n[b] = d[b]; // R7
      for (int i = 0; i < 4; i++) if (d[12+i]) n[8+i] = 1'b1; // R4
      for (int b = 40; b <= 43; b++) n[b] = d[b];             // R8
    end
    for (int i = 0; i < 4; i++) if (ts[i]) n[4+i] = 1'b1;     // R3
    return n;
  endfunction

  task automatic step(logic we, logic [63:0] d, logic [3:0] ts);
    wr_en = we; wdata = d; tset = ts;
    model = ref_next(model, we, d, ts);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; tset = '0;
  endtask

  task automatic check_all(string req);
    for (int id = 0; id < 4; id++) begin
      rid = id[1:0];
      #1;
      check({req, " R9 read"}, rdata, model | 64'(id));
    end
    check({req, " R11 ipi"}, {60'd0, ipi}, {60'd0, model[11:8]});
    check({req, " R11 tmr"}, {60'd0, tmr}, {60'd0, model[7:4]});
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");
    rid = 2'd3; #1;
    check("R1 reset id only", rdata, 64'd3);

    // R3: pulses set, writes only clear, set wins over clear
    step(1'b0, '0, 4'b0101);
    check("R3 pulse set", {60'd0, tmr}, 64'h5);
    step(1'b1, 64'h0000_00F0, 4'b0001);
    check("R3 set wins clear", {60'd0, tmr}, 64'h1);
    step(1'b1, 64'h0000_0010, 4'b0000);
    check("R3 write clears", {60'd0, tmr}, 64'h0);

    // R4: request sets ipi, not stored; set after clear
    step(1'b1, 64'h0000_2000, 4'b0);
    check("R4 request sets", {60'd0, ipi}, 64'h2);
    rid = 0; #1;
    check("R4 request not stored", rdata & 64'hF000, 64'h0);
    step(1'b1, 64'h0000_2200, 4'b0);
    check("R4 set after clear", {60'd0, ipi}, 64'h2);
    step(1'b1, 64'h0000_0200, 4'b0);
    check("R2 ipi clear", {60'd0, ipi}, 64'h0);

    // R5/R6/R7 arbitration fields
    step(1'b1, 64'h00A5_0000, 4'b0);
    rid = 0; #1;
    check("R7 load when zero", rdata & 64'hFF_0000, 64'hA5_0000);
    step(1'b1, 64'h000F_0000, 4'b0);
    rid = 0; #1;
    check("R7 hold when nonzero", rdata & 64'hFF_0000, 64'hA5_0000);
    step(1'b1, 64'h0040_0000, 4'b0);
    rid = 0; #1;
    check("R6 w1s", rdata & 64'hFF_0000, 64'hE5_0000);
    step(1'b1, 64'h0013_0000, 4'b0);
    rid = 0; #1;
    check("R5 clear then set", rdata & 64'hFF_0000, 64'h13_0000);

    // R8 user field
    step(1'b1, 64'h0000_0900_0000_0000, 4'b0);
    rid = 0; #1;
    check("R8 load", rdata & 64'h0F00_0000_0000, 64'h0900_0000_0000);
    step(1'b1, 64'h0, 4'b0);
    rid = 0; #1;
    check("R8 zero", rdata & 64'h0F00_0000_0000, 64'h0);

    // R10 / R2 bit 28: all-ones write
    step(1'b1, '1, 4'b0);
    rid = 0; #1;
    check("R10 undefined zero", rdata & ~64'h0000_0F00_10FF_0FF0, 64'h0);
    check("R2 bit28 zero", {63'd0, rdata[28]}, 64'h0);
    check_all("R10 all ones");

    // sweep
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] r;
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 7);
      rng = rng ^ (rng << 17);
      r = rng;
      if (r[2:0] == 3'd0) r[23:16] = r[23:16] & 8'h0F;
      step(r[61] | r[62], r, (r[63] && r[60]) ? r[47:44] : 4'b0);
      check_all("R2 R4 R5 R6 R7 R8 sweep");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule